// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block takes bytes from a host over a write-only serial link made of an active-low enable, a serial clock, a data line and a select line. The select line marks each byte as a command or as display-memory data. All four host wires are asynchronous to the system clock. Each wire passes through a multi-flop synchroniser, and rising serial-clock edges are then detected in the system clock domain. That clock must run at least four times faster than the serial bit rate.

Bits arrive most significant first. The select line is read only on the eighth rising edge of a byte. A finished byte is reported with a one-cycle valid pulse, together with the byte value and a data/command flag.

One class of command is held back instead of being reported. That class is every command byte whose value under a parameter mask equals a parameter pattern. Such a byte stays pending until the next byte of either kind completes. At that point it is released on a separate one-cycle pulse, which carries the held value.

Top module: `serial_byte_rx`

## Requirements
- R1: While `ser_en_n` is high, serial clock edges have no effect. Bits gathered before `ser_en_n` rose are discarded, and the first byte after it falls again is assembled from a fresh bit count.
- R2: `ser_dat` is sampled on each rising edge of `ser_clk`. The first bit of a byte lands in `byte_val[7]` and the eighth lands in `byte_val[0]`.
- R3: `byte_is_data` equals the level of `ser_dc` at the eighth rising edge: 1 means display data and 0 means command. The level of `ser_dc` at the other seven edges has no effect.
- R4: While `ser_en_n` stays low, the rising edge after a byte's eighth edge is bit 7 of the following byte, with no idle time required.
- R5: Each completed byte that is not a deferred command raises `byte_vld` for exactly one system cycle. The pulse is sampled at the fourth falling system-clock edge after the eighth serial rising edge is driven. Reset leaves `byte_vld` and `defer_fire` low.
- R6: A completed command byte with `(value & DEFER_MASK) == DEFER_MATCH` (defaults 8'hFC and 8'h04, so values 8'h04 to 8'h07) gives no `byte_vld`. It is held as pending instead.
- R7: When a byte of either kind completes while a command is pending, `defer_fire` pulses for one cycle in the same cycle as that byte's result, with `defer_val` carrying the held value. If the completing byte is itself deferrable, the old command fires and the new one becomes pending.
- R8: Reset aborts a partial byte and drops any pending command. If `ser_en_n` is low when reset is released, with `ser_clk` low, the next eight edges form a complete byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Serial enable, active low (asynchronous) |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first (asynchronous) |
| ser_dc | input | 1 | Select: 1 data, 0 command (asynchronous) |
| byte_vld | output | 1 | One-cycle pulse: byte completed |
| byte_val | output | 8 | Completed byte value |
| byte_is_data | output | 1 | Select level latched with the eighth bit |
| defer_fire | output | 1 | One-cycle pulse releasing the pending command |
| defer_val | output | 8 | Value of the released command |

## Verification
A rising edge on `ser_clk` goes through two synchroniser flops, the edge-detect and shift register, and the output register. Both `byte_vld` and `defer_fire` therefore appear after four system-clock edges. The bench drives every serial edge on a falling system-clock edge and inspects the outputs exactly four falling edges later. It holds the serial clock high long enough that the sample falls inside the bit's high phase. A monitor counts every pulse on each output over the whole run and compares the totals with the model. This catches stray or doubled pulses that the timed samples would miss.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              clk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-2:0] sh;
        logic              vld;
        logic [BYTE_W-1:0] val;
        logic              dc;
    } shift_st_t;

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] pval;
        logic              out_vld;
        logic [BYTE_W-1:0] out_val;
        logic              out_dc;
        logic              fire;
        logic [BYTE_W-1:0] fval;
    } defer_st_t;

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    assign stg_d[0] = din;

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            assign stg_d[g] = stg_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/sbr_shift.sv
module sbr_shift
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              sclk,
    input  logic              sdat,
    input  logic              sdc,
    output logic              vld,
    output logic [BYTE_W-1:0] val,
    output logic              dc
);

    shift_st_t st_d, st_q;
    logic      rise;

    assign rise = sclk && !st_q.clk_prev;

    always_comb begin
        st_d          = st_q;
        st_d.vld      = 1'b0;
        st_d.clk_prev = sclk;
        if (en_n) begin
            st_d.cnt = '0;
        end else if (rise) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.vld = 1'b1;
                st_d.val = {st_q.sh, sdat};
                st_d.dc  = sdc;
                st_d.cnt = '0;
            end else begin
                st_d.sh  = {st_q.sh[BYTE_W-3:0], sdat};
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld = st_q.vld;
    assign val = st_q.val;
    assign dc  = st_q.dc;

    AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (st_q.cnt == '0)); // R1
    AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !vld); // R1
    AST_LSB_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (val[0] == $past(sdat))); // R2
    AST_DC_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (dc == $past(sdc))); // R3
    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld); // R5

endmodule

// File: rtl/sbr_defer.sv
module sbr_defer
    import sbr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEFER_MASK  = 8'hFC,
    parameter logic [BYTE_W-1:0] DEFER_MATCH = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_val,
    input  logic              in_dc,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_val,
    output logic              out_dc,
    output logic              fire,
    output logic [BYTE_W-1:0] fval
);

    defer_st_t st_d, st_q;
    logic      is_def;

    assign is_def = !in_dc && ((in_val & DEFER_MASK) == DEFER_MATCH);

    always_comb begin
        st_d         = st_q;
        st_d.out_vld = 1'b0;
        st_d.fire    = 1'b0;
        if (in_vld) begin
            st_d.fire    = st_q.pend;
            st_d.fval    = st_q.pval;
            st_d.out_vld = !is_def;
            st_d.out_val = in_val;
            st_d.out_dc  = in_dc;
            st_d.pend    = is_def;
            if (is_def) st_d.pval = in_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.out_vld;
    assign out_val = st_q.out_val;
    assign out_dc  = st_q.out_dc;
    assign fire    = st_q.fire;
    assign fval    = st_q.fval;

    AST_DEFER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_dc && ((in_val & DEFER_MASK) == DEFER_MATCH)) |=> !out_vld); // R6
    AST_FIRE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(in_vld)); // R7
    AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R7
    AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !fire && !out_vld); // R5

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import sbr_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] DEFER_MASK  = 8'hFC,
    parameter logic [BYTE_W-1:0] DEFER_MATCH = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_dc,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic              byte_is_data,
    output logic              defer_fire,
    output logic [BYTE_W-1:0] defer_val
);

    localparam int NWIRE = 4;

    logic [NWIRE-1:0]  wires_sync;
    logic              sh_vld;
    logic [BYTE_W-1:0] sh_val;
    logic              sh_dc;

    sbr_sync #(
        .WIDTH   (NWIRE),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_dc, ser_dat, ser_clk, ser_en_n}),
        .dout  (wires_sync)
    );

    sbr_shift u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (wires_sync[0]),
        .sclk  (wires_sync[1]),
        .sdat  (wires_sync[2]),
        .sdc   (wires_sync[3]),
        .vld   (sh_vld),
        .val   (sh_val),
        .dc    (sh_dc)
    );

    sbr_defer #(
        .DEFER_MASK  (DEFER_MASK),
        .DEFER_MATCH (DEFER_MATCH)
    ) u_defer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (sh_vld),
        .in_val  (sh_val),
        .in_dc   (sh_dc),
        .out_vld (byte_vld),
        .out_val (byte_val),
        .out_dc  (byte_is_data),
        .fire    (defer_fire),
        .fval    (defer_val)
    );

    AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(sh_vld)); // R5

endmodule

// File: tb/serial_byte_rx_tb_top.sv
module serial_byte_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] MASK  = 8'hFC;
    localparam logic [7:0] MATCH = 8'h04;

    logic clk = 1'b0;
    logic rst_n, ser_en_n, ser_clk, ser_dat, ser_dc;
    logic byte_vld, byte_is_data, defer_fire;
    logic [7:0] byte_val, defer_val;

    int checks = 0, errors = 0;
    int seen_vld = 0, seen_fire = 0, exp_vld_n = 0, exp_fire_n = 0;
    bit done = 0;
    bit pend = 0;
    logic [7:0] pval = '0;

    serial_byte_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_dc(ser_dc), .byte_vld(byte_vld),
        .byte_val(byte_val), .byte_is_data(byte_is_data),
        .defer_fire(defer_fire), .defer_val(defer_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (byte_vld)   seen_vld++;
            if (defer_fire) seen_fire++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_def(input logic [7:0] b, input bit dc);
        return !dc && ((b & MASK) == MATCH);
    endfunction

    task automatic ser_bit(input bit v, input bit dc, input int hold);
        @(negedge clk);
        ser_clk = 1'b0; ser_dat = v; ser_dc = dc;
        repeat (2 + $urandom_range(2)) @(negedge clk);
        ser_clk = 1'b1;
        repeat (hold) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit dc, input string req);
        bit d, efire;
        logic [7:0] efv;
        for (int i = 7; i > 0; i--) ser_bit(b[i], 1'($urandom), 2);
        ser_bit(b[0], dc, 4);
        d = is_def(b, dc);
        efire = pend; efv = pval;
        chk(byte_vld == !d, {req, " R5 R6 byte_vld"}, byte_vld, !d);
        if (!d) begin
            chk(byte_val == b, {req, " R2 byte_val"}, byte_val, b);
            chk(byte_is_data == dc, {req, " R3 byte_is_data"}, byte_is_data, dc);
            exp_vld_n++;
        end
        chk(defer_fire == efire, {req, " R7 defer_fire"}, defer_fire, efire);
        if (efire) begin
            chk(defer_val == efv, {req, " R7 defer_val"}, defer_val, efv);
            exp_fire_n++;
        end
        pend = d;
        if (d) pval = b;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        ser_clk = 1'b0;
        rst_n = 1'b0;
        pend = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] rb;
        bit rdc;
        rb = 8'($urandom(32'd20240611));
        rst_n = 1'b0; ser_en_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; ser_dc = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!byte_vld && !defer_fire, "R5 reset state", {byte_vld, defer_fire}, 0);

        // R2 R3 R4: back-to-back bytes, MSB first
        ser_en_n = 1'b0;
        repeat (3) @(negedge clk);
        send_byte(8'hA5, 1'b1, "R2 data");
        send_byte(8'h3C, 1'b0, "R4 cmd");
        send_byte(8'h80, 1'b1, "R2 msb");
        send_byte(8'h01, 1'b0, "R2 lsb");

        // R6 R7: deferred command, released by data, then chained deferrals
        send_byte(8'h05, 1'b0, "R6 defer");
        send_byte(8'h81, 1'b1, "R7 release by data");
        send_byte(8'h06, 1'b0, "R6 defer a");
        send_byte(8'h07, 1'b0, "R7 defer chain");
        send_byte(8'h20, 1'b0, "R7 release by cmd");
        send_byte(8'h04, 1'b1, "R6 pattern as data");

        // R1: clock edges ignored while enable high
        ser_en_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) ser_bit(1'b1, 1'b1, 2);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        chk(seen_vld == exp_vld_n, "R1 no byte while disabled", seen_vld, exp_vld_n);
        ser_en_n = 1'b0;
        repeat (3) @(negedge clk);
        send_byte(8'h5A, 1'b1, "R1 after idle");
        // R1: partial byte dropped by enable high
        for (int i = 0; i < 3; i++) ser_bit(1'b1, 1'b0, 2);
        @(negedge clk); ser_clk = 1'b0; ser_en_n = 1'b1;
        repeat (4) @(negedge clk);
        ser_en_n = 1'b0;
        repeat (3) @(negedge clk);
        send_byte(8'h96, 1'b0, "R1 partial dropped");

        // R8: reset mid-byte, enable stays low
        for (int i = 0; i < 4; i++) ser_bit(1'b1, 1'b1, 2);
        do_reset();
        send_byte(8'h3E, 1'b1, "R8 after reset");
        // R8: pending command dropped by reset
        send_byte(8'h06, 1'b0, "R8 defer before reset");
        do_reset();
        send_byte(8'h11, 1'b1, "R8 pending cleared");

        // random traffic
        for (int n = 0; n < 40; n++) begin
            rb  = 8'($urandom);
            rdc = 1'($urandom);
            if ($urandom_range(3) == 0) begin
                rb = MATCH | 8'($urandom_range(3));
                rdc = 1'b0;
            end
            send_byte(rb, rdc, "R4 random");
        end

        repeat (8) @(negedge clk);
        chk(seen_vld == exp_vld_n, "R5 total byte_vld pulses", seen_vld, exp_vld_n);
        chk(seen_fire == exp_fire_n, "R7 total defer_fire pulses", seen_fire, exp_fire_n);
        finish_run();
    end

endmodule